// File: doc/BRIEF.md
# Buffered UART Transmit Path

This block is the transmit half of a serial port. A host pushes bytes through a single-cycle write strobe into a small first-in first-out queue (four entries by default). A shifter takes the oldest byte whenever the line is free and serialises it onto the `txd` output. Each frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. Bit timing comes from a free-running clock-enable divider, so every bit lasts `BAUD_DIV` clock cycles.

Two status outputs tell the host what it may do next. `tx_free` is high while the queue can accept another byte. It comes back one cycle after the shifter takes a byte out of a full queue. `tx_idle` is high only when the queue is empty and no frame is on the wire, which makes it safe to reconfigure or power down the port. An optional clear-to-send handshake (`cts_en`, `cts_n`) stops a new frame from starting while the far end is not ready. A frame that is already going out always completes.

Top module: `uart_txq_top`

## Requirements
- R1: The queue stores `DEPTH` (4) bytes, and bytes leave in the order they were written. A write is accepted on a clock edge where `wr_en` is 1 and `tx_free` is 1.
- R2: `tx_free` is 0 exactly when `DEPTH` bytes are stored. It returns to 1 on the cycle after the shifter takes a byte out of a full queue.
- R3: `tx_idle` is 1 exactly when the queue is empty and no frame is being sent. It drops on the cycle after a write into an idle block, and it rises only after the stop bit of the last byte has finished.
- R4: `txd` is 1 while no frame is being sent. A frame is one 0 start bit, then the 8 data bits with bit 0 first, then the optional parity bit, then one 1 stop bit. Each bit is held for `BAUD_DIV` cycles.
- R5: With `par_en`=1 a parity bit follows the data. It is the XOR of the data bits when `par_odd`=0 (even parity) and the inverse of that XOR when `par_odd`=1 (odd parity). With `par_en`=0 no parity bit is sent. The parity settings are sampled when a frame starts.
- R6: When `cts_en`=1 and `cts_n`=1, no new frame starts. A frame already in progress still runs to its stop bit. When `cts_en`=0, `cts_n` is ignored.
- R7: A write while `tx_free`=0 is ignored. The queued bytes and their order are unchanged.
- R8: The divider ticks every `BAUD_DIV` cycles, counted from reset (first tick on the `BAUD_DIV`-th edge after reset). Frames start only on a tick. When a byte is waiting, the next start bit directly follows the previous stop bit with no gap.
- R9: After reset `txd`=1, `tx_free`=1 and `tx_idle`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| par_en | input | 1 | 1 adds a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cts_en | input | 1 | 1 enables clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial output line |
| tx_free | output | 1 | Queue can take another byte |
| tx_idle | output | 1 | Queue empty and shifter quiet |

## Verification
The bench fills the queue while clear-to-send is held off and then writes one byte more. A design that let that write through would overwrite an entry or shift the order, and an extra or wrong frame would appear on `txd`. It checks that `tx_free` comes back exactly one cycle after the first byte moves out of a full queue, and that `tx_idle` stays low through the final stop bit. A flag computed from the queue alone would rise a whole frame too early. It also drops clear-to-send in the middle of a frame and sends both parity senses. A design that cut the frame short, started a frame while gated, or inverted parity would put a wrong bit on the line in the exact cycle the model compares.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int TXQ_DW = 8;            // data bits per frame
  localparam int TXQ_PW = TXQ_DW + 2;   // bits after the start bit, at most
  localparam int TXQ_LW = 4;            // width of a bit counter

  // parity bit: even parity is the XOR of the data, odd parity its inverse
  function automatic logic calc_parity(input logic [TXQ_DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // bits that follow the start bit, lowest bit sent first
  function automatic logic [TXQ_PW-1:0] build_payload(input logic [TXQ_DW-1:0] d,
                                                      input logic par_en,
                                                      input logic odd);
    if (par_en) return {1'b1, calc_parity(d, odd), d};
    return {2'b11, d};
  endfunction

  // number of bit periods that follow the start bit
  function automatic logic [TXQ_LW-1:0] payload_len(input logic par_en);
    return par_en ? TXQ_LW'(TXQ_DW + 2) : TXQ_LW'(TXQ_DW + 1);
  endfunction
endpackage

// File: rtl/txq_baud_gen.sv
module txq_baud_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end

  // R8: the tick lasts a single cycle
  a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV > 1 && tick) |=> !tick);
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [NW-1:0] FULL_N = NW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [NW-1:0] level_q;
  logic          push;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (level_q == FULL_N);
  assign empty   = (level_q == '0);
  assign push    = push_req && !full;   // full queue drops the write
  assign rd_data = mem_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push, pop})
        2'b10:   level_q <= level_q + NW'(1);
        2'b01:   level_q <= level_q - NW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  // R1: the shifter never takes from an empty queue
  a_r1_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R7: a write into a full queue leaves the level alone
  a_r7_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop) |=> (full && $stable(wr_ptr_q)));
endmodule

// File: rtl/txq_shifter.sv
module txq_shifter
  import txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              has_data,
  input  logic [TXQ_DW-1:0] data,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              cts_en,
  input  logic              cts_n,
  output logic              pop,
  output logic              txd,
  output logic              busy
);
  logic [TXQ_PW-1:0] shreg_q;
  logic [TXQ_LW-1:0] left_q;
  logic              txd_q, busy_q;
  logic              cts_ok, slot_open, frame_done;

  assign cts_ok     = !cts_en || !cts_n;
  assign frame_done = busy_q && (left_q == '0);        // stop bit has elapsed
  assign slot_open  = tick && (!busy_q || frame_done);
  assign pop        = slot_open && has_data && cts_ok;
  assign txd        = txd_q;
  assign busy       = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '1;
      left_q  <= '0;
      txd_q   <= 1'b1;
      busy_q  <= 1'b0;
    end else if (pop) begin
      shreg_q <= build_payload(data, par_en, par_odd);
      left_q  <= payload_len(par_en);
      txd_q   <= 1'b0;
      busy_q  <= 1'b1;
    end else if (tick && busy_q) begin
      if (frame_done) begin
        txd_q  <= 1'b1;
        busy_q <= 1'b0;
      end else begin
        txd_q   <= shreg_q[0];
        shreg_q <= {1'b1, shreg_q[TXQ_PW-1:1]};
        left_q  <= left_q - TXQ_LW'(1);
      end
    end
  end

  // R4: a quiet line is high
  a_r4_line_high_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R4: every frame opens with a low start bit
  a_r4_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  // R6: gated handshake keeps an idle shifter idle
  a_r6_cts_holds_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cts_en && cts_n && !busy) |=> !busy);
  // R8: the line only moves on a divider tick
  a_r8_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(txd) && $stable(busy)));
endmodule

// File: rtl/uart_txq_top.sv
module uart_txq_top
  import txq_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int BAUD_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TXQ_DW-1:0] wr_data,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              cts_en,
  input  logic              cts_n,
  output logic              txd,
  output logic              tx_free,
  output logic              tx_idle
);
  logic              tick;
  logic              pop, busy, empty, full;
  logic [TXQ_DW-1:0] head;

  txq_baud_gen #(.DIV(BAUD_DIV)) baud_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  txq_fifo #(.DW(TXQ_DW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push_req(wr_en), .wr_data(wr_data),
    .pop(pop), .rd_data(head), .empty(empty), .full(full)
  );

  txq_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .has_data(!empty), .data(head),
    .par_en(par_en), .par_odd(par_odd), .cts_en(cts_en), .cts_n(cts_n),
    .pop(pop), .txd(txd), .busy(busy)
  );

  assign tx_free = !full;
  assign tx_idle = empty && !busy;

  // R3: an idle path leaves the line high
  a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd);
  // R2: a slot opens the cycle after a full queue hands a byte over
  a_r2_free_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop) |=> tx_free);
  // R3: a write to an idle path clears the idle flag next cycle
  a_r3_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && wr_en) |=> !tx_idle);
endmodule

// File: tb/uart_txq_top_tb_top.sv
module uart_txq_top_tb_top;
  localparam int DEPTH = 4;
  localparam int DIV   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, par_en = 1'b0, par_odd = 1'b0, cts_en = 1'b0, cts_n = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, tx_free, tx_idle;

  int n_checks = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  uart_txq_top #(.DEPTH(DEPTH), .BAUD_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .par_en(par_en), .par_odd(par_odd), .cts_en(cts_en), .cts_n(cts_n),
    .txd(txd), .tx_free(tx_free), .tx_idle(tx_idle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // behavioural reference model
  int   m_div = 0;
  byte  m_q[$];
  bit   m_bits[$];
  int   m_pos = 0;
  bit   m_busy = 0, m_txd = 1;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_div = 0; m_q.delete(); m_bits.delete(); m_pos = 0; m_busy = 0; m_txd = 1;
    end else begin
      automatic bit tk  = (m_div == DIV - 1);
      automatic int sz0 = m_q.size();
      m_div = tk ? 0 : m_div + 1;
      if (tk) begin
        if (m_busy && m_pos < m_bits.size() - 1) begin
          m_pos++;
          m_txd = m_bits[m_pos];
        end else if (m_q.size() > 0 && (!cts_en || !cts_n)) begin
          automatic byte b = m_q.pop_front();
          automatic bit p = 1'b0;
          m_bits.delete();
          m_bits.push_back(1'b0);
          for (int i = 0; i < 8; i++) begin
            m_bits.push_back(b[i]);
            p = p ^ b[i];
          end
          if (par_en) m_bits.push_back(par_odd ? ~p : p);
          m_bits.push_back(1'b1);
          m_pos = 0; m_busy = 1; m_txd = 1'b0;
        end else begin
          m_busy = 0; m_txd = 1'b1;
        end
      end
      if (wr_en && sz0 < DEPTH) m_q.push_back(wr_data);
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(txd == m_txd, "R4 R5 R6 R7 R8 line", int'(txd), int'(m_txd));
      check(tx_free == (m_q.size() < DEPTH), "R1 R2 free", int'(tx_free),
            int'(m_q.size() < DEPTH));
      check(tx_idle == (m_q.size() == 0 && !m_busy), "R3 idle", int'(tx_idle),
            int'(m_q.size() == 0 && !m_busy));
    end
  end

  task automatic put(input byte b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && !tx_idle; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check(txd == 1'b1, "R9 txd", int'(txd), 1);
    check(tx_free == 1'b1, "R9 tx_free", int'(tx_free), 1);
    check(tx_idle == 1'b1, "R9 tx_idle", int'(tx_idle), 1);

    // R3: write into idle path drops idle next cycle
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hA5;
    @(negedge clk);
    wr_en = 1'b0;
    check(tx_idle == 1'b0, "R3 idle after write", int'(tx_idle), 0);
    wait_idle();

    // R5 even then odd parity, R8 back-to-back
    par_en = 1'b1; par_odd = 1'b0;
    put(8'h3C); put(8'h01);
    wait_idle();
    par_odd = 1'b1;
    put(8'hF7); put(8'h00);
    wait_idle();
    par_en = 1'b0;

    // R6 gate, R2/R7 fill past full
    cts_en = 1'b1; cts_n = 1'b1;
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    check(tx_free == 1'b0, "R2 full clears free", int'(tx_free), 0);
    put(8'h55);  // R7: dropped
    check(tx_free == 1'b0, "R7 still full", int'(tx_free), 0);
    repeat (60) @(negedge clk);
    check(txd == 1'b1, "R6 line held", int'(txd), 1);
    check(tx_idle == 1'b0, "R6 not idle while gated", int'(tx_idle), 0);
    cts_n = 1'b0;
    for (int i = 0; i < 3 * DIV && !tx_free; i++) @(negedge clk);
    check(tx_free == 1'b1, "R2 free after handover", int'(tx_free), 1);
    // R6 mid-frame deassert: current frame must complete
    repeat (5 * DIV) @(negedge clk);
    cts_n = 1'b1;
    repeat (120) @(negedge clk);
    check(tx_idle == 1'b0, "R6 queue held", int'(tx_idle), 0);
    check(txd == 1'b1, "R6 frame finished high", int'(txd), 1);
    cts_n = 1'b0;
    wait_idle();
    check(tx_idle == 1'b1, "R1 drained", int'(tx_idle), 1);

    // R6: cts_n ignored when gating disabled
    cts_en = 1'b0; cts_n = 1'b1;
    put(8'h9E);
    wait_idle();
    check(tx_idle == 1'b1, "R6 ignore when disabled", int'(tx_idle), 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule